// File: doc/BRIEF.md
# Four-Phase Handshake Word Bridge

This block carries one data word at a time from a sending clock domain to a receiving clock domain that runs on an unrelated clock. It also carries one return word back on every transfer. The user on the sending side offers a word with `s_valid`. When the bridge is idle it latches the word and raises a request line. A register chain in the receiving domain brings the request across. When the synchronized request shows up, the receiver samples the forward bus and emits the word on `r_valid`/`r_data`. On the same edge it latches the user's return word and raises an acknowledge. A second register chain brings the acknowledge back to the sender. The sender then captures the return word and drops the request. The transfer is finished once the receiver has dropped the acknowledge and the sender has seen that drop through its chain.

Only the request and acknowledge lines pass through synchronizer chains, and each passes through exactly one chain. Both data buses are held steady by their owner and are sampled only after the matching control edge has been synchronized. Each chain has its own depth parameter, with a minimum of two stages. Deeper chains give more settling time when the clocks are fast.

Top module: `hs_xfer`

## Requirements
- R1: While either reset is asserted, and after it is released, `s_busy`, `s_ret_valid` and `r_valid` are all low.
- R2: The request rises only when the synchronized acknowledge is low and falls only when the synchronized acknowledge is high. `s_busy` stays high after the return word arrives and clears only once the synchronized acknowledge has gone low again, so both lines return to zero.
- R3: The forward word register is held constant for the whole time `s_busy` is high. Changing `s_data` after acceptance does not alter the delivered word.
- R4: When the receiver sees the synchronized request high while its acknowledge is low, it pulses `r_valid` for exactly one `r_clk` cycle with the forward word on `r_data`, and raises the acknowledge on the same edge.
- R5: The receiver lowers its acknowledge only after the synchronized request is low. A new word is delivered only after this lowering.
- R6: The receiver latches `r_ret_data` on the edge where it captures the forward word. The sender presents that value on `s_ret_data` with a one-cycle `s_ret_valid` pulse when the synchronized acknowledge arrives.
- R7: `s_valid` is accepted only when `s_busy` is low. `s_busy` is high from the next `s_clk` edge onward. Any `s_valid` asserted while `s_busy` is high is ignored, and that word is never delivered.
- R8: Every accepted word is delivered exactly once, in order and unchanged. Every return word reaches the sender exactly once and in order.
- R9: The request passes through `R_SYNC` stages and the acknowledge through `S_SYNC` stages. A word therefore cannot appear on `r_data` earlier than `R_SYNC` `r_clk` periods after the `s_clk` edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Sending-domain clock |
| s_rst_n | input | 1 | Sending-domain asynchronous reset, active low |
| s_valid | input | 1 | Sender offers a word |
| s_data | input | FWD_W | Word offered by the sender |
| s_busy | output | 1 | Transfer in progress; new offers are ignored |
| s_ret_valid | output | 1 | One-cycle pulse: return word available |
| s_ret_data | output | RET_W | Return word from the receiving side |
| r_clk | input | 1 | Receiving-domain clock |
| r_rst_n | input | 1 | Receiving-domain asynchronous reset, active low |
| r_valid | output | 1 | One-cycle pulse: forward word delivered |
| r_data | output | FWD_W | Delivered forward word |
| r_ret_data | input | RET_W | Return word sampled at delivery |

## Verification
The riskiest cycle on the sending side is the one where the synchronized acknowledge arrives, because three things happen on that edge. The return word is captured, the request drops, and the user may still be presenting a new `s_valid`. The bench provokes this on alternating transfers. It holds `s_valid` high with a marker word from just after acceptance until it sees `s_ret_valid`, so the marker is present on the acknowledge edge. The result is judged from three observations: the return word must match, `s_busy` must still be high after the return pulse, and the marker must never reach `r_data`.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_REQ  = 2'd1,
        TX_RTZ  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/hs_sync_chain.sv
module hs_sync_chain #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = DEPTH - 1;

    logic [LAST:0] stg_d, stg_q;

    generate
        if (DEPTH > 1) begin : g_multi
            always_comb stg_d = {stg_q[LAST-1:0], d};
        end else begin : g_single
            always_comb stg_d = d;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[LAST];
endmodule

// File: rtl/hs_xfer_tx.sv
module hs_xfer_tx
    import hs_xfer_pkg::*;
#(
    parameter int FWD_W = 16,
    parameter int RET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [FWD_W-1:0] data,
    output logic             busy,
    output logic             ret_valid,
    output logic [RET_W-1:0] ret_data,
    output logic             req_o,
    output logic [FWD_W-1:0] fwd_o,
    input  logic             ack_s,
    input  logic [RET_W-1:0] ret_i
);
    typedef struct packed {
        tx_state_e        st;
        logic             req;
        logic [FWD_W-1:0] fwd;
        logic             rvld;
        logic [RET_W-1:0] ret;
    } tx_reg_t;

    tx_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.rvld = 1'b0;
        unique case (cur_q.st)
            TX_IDLE: if (valid) begin
                nxt_d.fwd = data;
                nxt_d.req = 1'b1;
                nxt_d.st  = TX_REQ;
            end
            TX_REQ: if (ack_s) begin
                nxt_d.ret  = ret_i;
                nxt_d.rvld = 1'b1;
                nxt_d.req  = 1'b0;
                nxt_d.st   = TX_RTZ;
            end
            TX_RTZ: if (!ack_s) nxt_d.st = TX_IDLE;
            default: nxt_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: TX_IDLE, req: 1'b0, fwd: '0, rvld: 1'b0, ret: '0};
        else        cur_q <= nxt_d;
    end

    assign busy      = (cur_q.st != TX_IDLE);
    assign ret_valid = cur_q.rvld;
    assign ret_data  = cur_q.ret;
    assign req_o     = cur_q.req;
    assign fwd_o     = cur_q.fwd;

    // R2: request edges follow the synchronized acknowledge
    a_r2_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> !$past(ack_s));
    a_r2_req_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> $past(ack_s));
    // R3: forward word frozen while a transfer is open
    a_r3_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fwd_o));
    // R6: return pulse only on the ack arrival edge
    a_r6_ret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (busy && !req_o));
endmodule

// File: rtl/hs_xfer_rx.sv
module hs_xfer_rx #(
    parameter int FWD_W = 16,
    parameter int RET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s,
    input  logic [FWD_W-1:0] fwd_i,
    output logic             ack_o,
    output logic [RET_W-1:0] ret_o,
    output logic             valid,
    output logic [FWD_W-1:0] data,
    input  logic [RET_W-1:0] ret_data
);
    typedef struct packed {
        logic             ack;
        logic             vld;
        logic [FWD_W-1:0] dat;
        logic [RET_W-1:0] ret;
    } rx_reg_t;

    rx_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (!cur_q.ack && req_s) begin
            nxt_d.dat = fwd_i;
            nxt_d.ret = ret_data;
            nxt_d.vld = 1'b1;
            nxt_d.ack = 1'b1;
        end else if (cur_q.ack && !req_s) begin
            nxt_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ack_o = cur_q.ack;
    assign ret_o = cur_q.ret;
    assign valid = cur_q.vld;
    assign data  = cur_q.dat;

    // R4: ack rises only on a seen request, together with the delivery pulse
    a_r4_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> ($past(req_s) && valid));
    a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R5: ack falls only after the request is seen low
    a_r5_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> !$past(req_s));
    // R6: return word held while ack is up
    a_r6_ret_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && $past(ack_o)) |-> $stable(ret_o));
endmodule

// File: rtl/hs_xfer.sv
module hs_xfer #(
    parameter int FWD_W  = 16,
    parameter int RET_W  = 8,
    parameter int S_SYNC = 2,
    parameter int R_SYNC = 2
) (
    input  logic             s_clk,
    input  logic             s_rst_n,
    input  logic             s_valid,
    input  logic [FWD_W-1:0] s_data,
    output logic             s_busy,
    output logic             s_ret_valid,
    output logic [RET_W-1:0] s_ret_data,
    input  logic             r_clk,
    input  logic             r_rst_n,
    output logic             r_valid,
    output logic [FWD_W-1:0] r_data,
    input  logic [RET_W-1:0] r_ret_data
);
    logic             req_q, req_sync;
    logic             ack_q, ack_sync;
    logic [FWD_W-1:0] fwd_bus;
    logic [RET_W-1:0] ret_bus;

    hs_xfer_tx #(.FWD_W(FWD_W), .RET_W(RET_W)) u_tx (
        .clk(s_clk), .rst_n(s_rst_n), .valid(s_valid), .data(s_data),
        .busy(s_busy), .ret_valid(s_ret_valid), .ret_data(s_ret_data),
        .req_o(req_q), .fwd_o(fwd_bus), .ack_s(ack_sync), .ret_i(ret_bus)
    );

    // R9: single chain per crossing control line
    hs_sync_chain #(.DEPTH(R_SYNC)) u_req_sync (
        .clk(r_clk), .rst_n(r_rst_n), .d(req_q), .q(req_sync)
    );

    hs_sync_chain #(.DEPTH(S_SYNC)) u_ack_sync (
        .clk(s_clk), .rst_n(s_rst_n), .d(ack_q), .q(ack_sync)
    );

    hs_xfer_rx #(.FWD_W(FWD_W), .RET_W(RET_W)) u_rx (
        .clk(r_clk), .rst_n(r_rst_n), .req_s(req_sync), .fwd_i(fwd_bus),
        .ack_o(ack_q), .ret_o(ret_bus), .valid(r_valid), .data(r_data),
        .ret_data(r_ret_data)
    );
endmodule

// File: tb/hs_xfer_tb_top.sv
`timescale 1ns/1ps
module hs_xfer_tb_top;
    localparam int    FW     = 16;
    localparam int    RW     = 8;
    localparam int    S_SYNC = 2;
    localparam int    R_SYNC = 3;
    localparam int    NWORDS = 14;
    localparam real   R_HALF = 3.65;

    logic          s_clk = 1'b0, r_clk = 1'b0;
    logic          s_rst_n = 1'b0, r_rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic [FW-1:0] s_data = '0;
    logic          s_busy, s_ret_valid, r_valid;
    logic [RW-1:0] s_ret_data, r_ret_data;
    logic [FW-1:0] r_data;

    int      n_chk = 0, n_err = 0;
    int      rcnt = 0, scnt = 0;
    bit      done = 1'b0;
    realtime t_acc = 0.0;
    logic [FW-1:0] exp_q[$];

    always #2.5    s_clk = ~s_clk;
    always #R_HALF r_clk = ~r_clk;

    function automatic logic [RW-1:0] ret_val(input int i);
        return RW'(8'h5A ^ (i * 3));
    endfunction

    assign r_ret_data = ret_val(rcnt);

    hs_xfer #(.FWD_W(FW), .RET_W(RW), .S_SYNC(S_SYNC), .R_SYNC(R_SYNC)) dut_i (
        .s_clk(s_clk), .s_rst_n(s_rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_busy(s_busy), .s_ret_valid(s_ret_valid), .s_ret_data(s_ret_data),
        .r_clk(r_clk), .r_rst_n(r_rst_n), .r_valid(r_valid), .r_data(r_data),
        .r_ret_data(r_ret_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // receive-side monitor: R4, R8, R9
    always @(negedge r_clk) begin
        if (r_rst_n && r_valid && !done) begin
            chk(exp_q.size() > 0, "R8 unexpected delivery (ignored word leaked, R7)", r_data, 0);
            if (exp_q.size() > 0) begin
                logic [FW-1:0] e;
                e = exp_q.pop_front();
                chk(r_data == e, "R4/R8 delivered word", r_data, e);
            end
            chk(($realtime - t_acc) >= R_SYNC * 2.0 * R_HALF, "R9 minimum sync latency",
                longint'($realtime - t_acc), longint'(R_SYNC * 2.0 * R_HALF));
            rcnt++;
        end
    end

    // send-side monitor: R6, R2
    always @(negedge s_clk) begin
        if (s_rst_n && s_ret_valid && !done) begin
            chk(s_ret_data == ret_val(scnt), "R6 return word", s_ret_data, ret_val(scnt));
            chk(s_busy == 1'b1, "R2 busy held for return-to-zero", s_busy, 1);
            scnt++;
        end
    end

    task automatic send(input logic [FW-1:0] d, input bit hammer);
        @(negedge s_clk);
        while (s_busy) @(negedge s_clk);
        s_valid = 1'b1;
        s_data  = d;
        exp_q.push_back(d);
        @(posedge s_clk);
        t_acc = $realtime;
        @(negedge s_clk);
        chk(s_busy == 1'b1, "R7 busy after accept", s_busy, 1);
        s_valid = 1'b0;
        s_data  = ~d;                 // R3: source changes, delivered word must not
        if (hammer) begin
            s_valid = 1'b1;           // R7: ignored while busy, overlaps ack arrival
            s_data  = 16'hDEAD;
            while (!s_ret_valid) @(negedge s_clk);
            s_valid = 1'b0;
            chk(s_busy == 1'b1, "R7 busy still high after marker", s_busy, 1);
        end
    endtask

    initial begin
        repeat (4) @(negedge s_clk);
        chk(s_busy == 1'b0, "R1 busy in reset", s_busy, 0);
        chk(s_ret_valid == 1'b0, "R1 ret_valid in reset", s_ret_valid, 0);
        chk(r_valid == 1'b0, "R1 r_valid in reset", r_valid, 0);
        s_rst_n = 1'b1;
        r_rst_n = 1'b1;
        repeat (3) @(negedge s_clk);
        chk(s_busy == 1'b0, "R1 busy after reset", s_busy, 0);
        chk(r_valid == 1'b0, "R1 r_valid after reset", r_valid, 0);

        for (int k = 0; k < NWORDS; k++)
            send(FW'(16'h1000 + k * 16'h0931), k[0]);

        @(negedge s_clk);
        while (s_busy) @(negedge s_clk);
        repeat (20) @(negedge s_clk);
        chk(s_busy == 1'b0, "R5 handshake back to idle", s_busy, 0);
        chk(rcnt == NWORDS, "R8 delivered count (R7 ignored words absent)", rcnt, NWORDS);
        chk(scnt == NWORDS, "R6 return count", scnt, NWORDS);
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", rcnt, NWORDS);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule